// File: doc/BRIEF.md
# Quarter-Word Multiply-Accumulate Unit

This unit takes two 256-bit source words, picks one 64-bit quarter of each, multiplies the two quarters and adds the 128-bit product into a 256-bit accumulator that lives inside the unit. Before the add, the product can be moved up by 0, 64, 128 or 192 bits. A clear control lets a new accumulation start without a separate reset step. Sums wider than 256 bits wrap.

Every valid operation also picks one of three writeback modes. The first updates only the accumulator. The second also sends the whole new accumulator to the destination register. The third sends the low 128 bits of the new accumulator into one chosen half of the destination and keeps the other half from the destination's current value. In that mode the accumulator then keeps only the upper 128 bits, moved down by 128. The register file lives outside this unit. It supplies the current destination value and takes the registered write request.

Top module: `qmac_unit`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, acc_o is zero and wr_en_o is 0.
- R2: Select value k on sel_a_i or sel_b_i picks bits 64k+63 down to 64k of its own source. The two selects are independent.
- R3: When clear_acc_i is 1, the new accumulator is the shifted product alone. When it is 0, the new accumulator is the old one plus the shifted product.
- R4: The 128-bit product is shifted left by 64 times shift_i (0, 64, 128 or 192 bits) before it is added.
- R5: Any sum bits above bit 255, and any shifted product bits above bit 255, are dropped (addition modulo 2^256).
- R6: mode_i = 0 (accumulate only) updates acc_o and leaves wr_en_o at 0 in the next cycle.
- R7: mode_i = 1 (full write) sets wr_en_o in the next cycle, with wr_data_o equal to the new accumulator. acc_o also holds that same value.
- R8: mode_i = 2 (half write) sets wr_en_o in the next cycle. half_sel_i = 0 puts the new accumulator's bits 127:0 into wr_data_o[127:0] and keeps wr_data_o[255:128] from dst_old_i. half_sel_i = 1 puts them into wr_data_o[255:128] and keeps wr_data_o[127:0] from dst_old_i. acc_o becomes the new accumulator shifted right by 128.
- R9: A cycle with valid_i low leaves acc_o unchanged, and wr_en_o is 0 in the next cycle, whatever the other inputs are.
- R10: mode_i = 3 behaves exactly like mode 0.
- R11: The accumulator update and the write request take effect on the same rising edge. Both are visible in the cycle after the valid operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| src_a_i | input | 256 | First source word |
| src_b_i | input | 256 | Second source word |
| sel_a_i | input | 2 | Quarter-word select for the first source |
| sel_b_i | input | 2 | Quarter-word select for the second source |
| clear_acc_i | input | 1 | Treat the old accumulator as zero |
| shift_i | input | 2 | Product shift, in units of 64 bits |
| mode_i | input | 2 | Writeback mode: 0 accumulate, 1 full, 2 half, 3 as 0 |
| half_sel_i | input | 1 | Destination half for mode 2 (0 low, 1 high) |
| dst_old_i | input | 256 | Current destination value, used for merging |
| wr_en_o | output | 1 | Destination write request |
| wr_data_o | output | 256 | Destination write data |
| acc_o | output | 256 | Accumulator value |

## Verification
The accumulator is state that is never reloaded, so a wrong value does not stay hidden. It appears on acc_o in the cycle after the operation that caused it, and it carries into every later result until a clear. Errors in quarter selection or shifting show up one cycle later as a wrong bit range in acc_o. Errors in the half merge or the 128-bit right shift show up in that same cycle on wr_data_o, and one cycle later in the next operation's sum. A behavioural model in the bench compares acc_o and wr_en_o after every clock, and compares wr_data_o whenever a write is expected.

// File: rtl/qmac_pkg.sv
package qmac_pkg;
  localparam int unsigned QW_W  = 64;
  localparam int unsigned NQ    = 4;
  localparam int unsigned ACC_W = QW_W * NQ;

  typedef enum logic [1:0] {
    WB_NONE = 2'd0,
    WB_FULL = 2'd1,
    WB_HALF = 2'd2,
    WB_RSVD = 2'd3
  } wb_mode_e;
endpackage

// File: rtl/qmac_qsel.sv
module qmac_qsel #(
  parameter int unsigned QW_W = 64,
  parameter int unsigned NQ   = 4,
  localparam int unsigned SEL_W = $clog2(NQ)
) (
  input  logic [QW_W*NQ-1:0] word_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [QW_W-1:0]    q_o
);
  logic [QW_W-1:0] parts [NQ];

  for (genvar k = 0; k < NQ; k++) begin : g_part
    assign parts[k] = word_i[k*QW_W +: QW_W];
  end

  assign q_o = parts[sel_i];
endmodule

// File: rtl/qmac_product.sv
module qmac_product #(
  parameter int unsigned QW_W = 64,
  parameter int unsigned NQ   = 4,
  localparam int unsigned ACC_W = QW_W * NQ,
  localparam int unsigned SH_W  = $clog2(NQ)
) (
  input  logic [QW_W-1:0]  a_i,
  input  logic [QW_W-1:0]  b_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic [ACC_W-1:0] term_o
);
  logic [2*QW_W-1:0] prod;
  logic [ACC_W-1:0]  prod_ext;
  logic [ACC_W-1:0]  cand [NQ];

  assign prod     = a_i * b_i;
  assign prod_ext = ACC_W'(prod);

  // one candidate per quarter-word shift; bits past the top are dropped
  for (genvar k = 0; k < NQ; k++) begin : g_shift
    assign cand[k] = prod_ext << (k * QW_W);
  end

  assign term_o = cand[shift_i];
endmodule

// File: rtl/qmac_writeback.sv
module qmac_writeback
  import qmac_pkg::*;
#(
  parameter int unsigned ACC_W = 256,
  localparam int unsigned HALF_W = ACC_W / 2
) (
  input  logic [1:0]       mode_i,
  input  logic             half_sel_i,
  input  logic [ACC_W-1:0] sum_i,
  input  logic [ACC_W-1:0] dst_old_i,
  output logic             wr_en_o,
  output logic [ACC_W-1:0] wr_data_o,
  output logic [ACC_W-1:0] acc_next_o
);
  logic [ACC_W-1:0] merged;

  always_comb begin
    if (half_sel_i) merged = {sum_i[HALF_W-1:0], dst_old_i[HALF_W-1:0]};
    else            merged = {dst_old_i[ACC_W-1:HALF_W], sum_i[HALF_W-1:0]};
  end

  always_comb begin
    wr_en_o    = 1'b0;
    wr_data_o  = sum_i;
    acc_next_o = sum_i;
    unique case (wb_mode_e'(mode_i))
      WB_FULL: wr_en_o = 1'b1;
      WB_HALF: begin
        wr_en_o    = 1'b1;
        wr_data_o  = merged;
        acc_next_o = sum_i >> HALF_W;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qmac_unit.sv
module qmac_unit
  import qmac_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [ACC_W-1:0] src_a_i,
  input  logic [ACC_W-1:0] src_b_i,
  input  logic [1:0]       sel_a_i,
  input  logic [1:0]       sel_b_i,
  input  logic             clear_acc_i,
  input  logic [1:0]       shift_i,
  input  logic [1:0]       mode_i,
  input  logic             half_sel_i,
  input  logic [ACC_W-1:0] dst_old_i,
  output logic             wr_en_o,
  output logic [ACC_W-1:0] wr_data_o,
  output logic [ACC_W-1:0] acc_o
);
  logic [QW_W-1:0]  qa, qb;
  logic [ACC_W-1:0] term, base, sum, acc_next, wdata_next;
  logic             wen_next;
  logic [ACC_W-1:0] acc_q, wdata_q;
  logic             wen_q;

  qmac_qsel #(.QW_W(QW_W), .NQ(NQ)) u_sel_a (
    .word_i(src_a_i), .sel_i(sel_a_i), .q_o(qa)
  );

  qmac_qsel #(.QW_W(QW_W), .NQ(NQ)) u_sel_b (
    .word_i(src_b_i), .sel_i(sel_b_i), .q_o(qb)
  );

  qmac_product #(.QW_W(QW_W), .NQ(NQ)) u_prod (
    .a_i(qa), .b_i(qb), .shift_i(shift_i), .term_o(term)
  );

  assign base = clear_acc_i ? '0 : acc_q;
  assign sum  = base + term;

  qmac_writeback #(.ACC_W(ACC_W)) u_wb (
    .mode_i     (mode_i),
    .half_sel_i (half_sel_i),
    .sum_i      (sum),
    .dst_old_i  (dst_old_i),
    .wr_en_o    (wen_next),
    .wr_data_o  (wdata_next),
    .acc_next_o (acc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      wen_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      wen_q <= valid_i & wen_next;
      if (valid_i) begin
        acc_q <= acc_next;
        if (wen_next) wdata_q <= wdata_next;
      end
    end
  end

  assign acc_o     = acc_q;
  assign wr_en_o   = wen_q;
  assign wr_data_o = wdata_q;
endmodule

// File: rtl/qmac_checker.sv
module qmac_checker #(
  parameter int unsigned ACC_W = 256,
  localparam int unsigned HALF_W = ACC_W / 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       mode_i,
  input logic             half_sel_i,
  input logic [ACC_W-1:0] dst_old_i,
  input logic             wr_en_o,
  input logic [ACC_W-1:0] wr_data_o,
  input logic [ACC_W-1:0] acc_o
);
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(acc_o) && !wr_en_o));

  assert_acc_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd0) |=> !wr_en_o);

  assert_rsvd_mode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd3) |=> !wr_en_o);

  assert_full_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd1) |=> (wr_en_o && wr_data_o == acc_o));

  assert_half_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd2 && !half_sel_i) |=>
      (wr_en_o && wr_data_o[ACC_W-1:HALF_W] == $past(dst_old_i[ACC_W-1:HALF_W])
       && acc_o[ACC_W-1:HALF_W] == '0));

  assert_half_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd2 && half_sel_i) |=>
      (wr_en_o && wr_data_o[HALF_W-1:0] == $past(dst_old_i[HALF_W-1:0])
       && acc_o[ACC_W-1:HALF_W] == '0));

  always_comb begin
    if (!rst_ni) assert_reset_R1: assert (acc_o == '0 && !wr_en_o);
  end
endmodule

bind qmac_unit qmac_checker #(.ACC_W(qmac_pkg::ACC_W)) u_qmac_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .mode_i     (mode_i),
  .half_sel_i (half_sel_i),
  .dst_old_i  (dst_old_i),
  .wr_en_o    (wr_en_o),
  .wr_data_o  (wr_data_o),
  .acc_o      (acc_o)
);

// File: tb/qmac_unit_tb_top.sv
`timescale 1ns/1ps
module qmac_unit_tb_top;
  localparam int W = 256;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid;
  logic [W-1:0] src_a, src_b, dst_old;
  logic [1:0]   sel_a, sel_b, shift, mode;
  logic         clear_acc, half_sel;
  logic         wr_en;
  logic [W-1:0] wr_data, acc;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_acc, m_wdata;
  logic         m_wr;

  always #2 clk = ~clk;

  qmac_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid),
    .src_a_i(src_a), .src_b_i(src_b), .sel_a_i(sel_a), .sel_b_i(sel_b),
    .clear_acc_i(clear_acc), .shift_i(shift), .mode_i(mode),
    .half_sel_i(half_sel), .dst_old_i(dst_old),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .acc_o(acc)
  );

  function automatic logic [W-1:0] rnd256();
    logic [W-1:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check_outputs(string tag);
    checks++;
    if (acc !== m_acc) begin
      errors++;
      $display("FAIL %s acc_o act=%h exp=%h", tag, acc, m_acc);
    end
    checks++;
    if (wr_en !== m_wr) begin
      errors++;
      $display("FAIL %s wr_en_o act=%b exp=%b", tag, wr_en, m_wr);
    end
    if (m_wr) begin
      checks++;
      if (wr_data !== m_wdata) begin
        errors++;
        $display("FAIL %s wr_data_o act=%h exp=%h", tag, wr_data, m_wdata);
      end
    end
  endtask

  // called at a falling edge; checks one cycle later
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [1:0] sa, input logic [1:0] sb,
                        input logic clr, input logic [1:0] sh,
                        input logic [1:0] md, input logic hs,
                        input logic [W-1:0] dst, input string tag);
    logic [127:0] p;
    logic [W-1:0] t, nv;
    valid = 1'b1; src_a = a; src_b = b; sel_a = sa; sel_b = sb;
    clear_acc = clr; shift = sh; mode = md; half_sel = hs; dst_old = dst;
    p  = {64'b0, a[sa*64 +: 64]} * {64'b0, b[sb*64 +: 64]};
    t  = {128'b0, p} << (64 * sh);
    nv = (clr ? '0 : m_acc) + t;
    case (md)
      2'd1: begin m_wr = 1'b1; m_wdata = nv; m_acc = nv; end
      2'd2: begin
        m_wr = 1'b1;
        m_wdata = hs ? {nv[127:0], dst[127:0]} : {dst[255:128], nv[127:0]};
        m_acc = nv >> 128;
      end
      default: begin m_wr = 1'b0; m_acc = nv; end
    endcase
    @(negedge clk);
    valid = 1'b0;
    check_outputs(tag);
  endtask

  task automatic idle(input string tag);
    valid = 1'b0; src_a = rnd256(); src_b = rnd256(); dst_old = rnd256();
    sel_a = 2'($urandom); sel_b = 2'($urandom); clear_acc = 1'b1;
    shift = 2'($urandom); mode = 2'd1; half_sel = 1'b1;
    m_wr = 1'b0;
    @(negedge clk);
    check_outputs(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
  end

  initial begin
    logic [W-1:0] pa, pb, ones;
    rst_n = 1'b0; valid = 1'b0; src_a = '0; src_b = '0; dst_old = '0;
    sel_a = '0; sel_b = '0; clear_acc = 1'b0; shift = '0; mode = '0; half_sel = 1'b0;
    m_acc = '0; m_wr = 1'b0; m_wdata = '0;
    repeat (3) @(negedge clk);
    check_outputs("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1 after reset");

    // R2: each quarter is distinct and each select pair is tried
    for (int i = 0; i < 4; i++) begin
      pa[i*64 +: 64] = 64'h1000_0000_0000_0001 * (i + 3);
      pb[i*64 +: 64] = 64'h0000_0001_0000_0007 + 64'(i * 11);
    end
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        run_op(pa, pb, 2'(i), 2'(j), 1'b1, 2'd0, 2'd0, 1'b0, '0, "R2 select");

    // R3: accumulate then clear
    run_op(pa, pb, 2'd1, 2'd2, 1'b0, 2'd0, 2'd0, 1'b0, '0, "R3 accumulate");
    run_op(pa, pb, 2'd3, 2'd0, 1'b0, 2'd1, 2'd0, 1'b0, '0, "R3 accumulate");
    run_op(pa, pb, 2'd0, 2'd0, 1'b1, 2'd0, 2'd0, 1'b0, '0, "R3 clear");

    // R4: every shift amount
    for (int s = 0; s < 4; s++)
      run_op(pa, pb, 2'd2, 2'd3, 1'b1, 2'(s), 2'd0, 1'b0, '0, "R4 shift");

    // R5: top-end wrap of product and of sum
    ones = '1;
    run_op(ones, ones, 2'd3, 2'd3, 1'b1, 2'd3, 2'd0, 1'b0, '0, "R5 product wrap");
    run_op(ones, ones, 2'd0, 2'd1, 1'b0, 2'd2, 2'd0, 1'b0, '0, "R5 sum wrap");
    run_op(ones, ones, 2'd0, 2'd1, 1'b0, 2'd3, 2'd0, 1'b0, '0, "R5 sum wrap");

    // R9: idle cycles with junk inputs keep state
    idle("R9 idle");
    idle("R9 idle");

    // R6, R7, R8, R10, R11
    run_op(pa, pb, 2'd1, 2'd1, 1'b0, 2'd1, 2'd0, 1'b0, rnd256(), "R6 acc only");
    run_op(pa, pb, 2'd2, 2'd1, 1'b0, 2'd2, 2'd1, 1'b0, rnd256(), "R7 full write");
    run_op(pa, pb, 2'd3, 2'd3, 1'b0, 2'd1, 2'd2, 1'b0, rnd256(), "R8 half low");
    run_op(ones, ones, 2'd3, 2'd2, 1'b0, 2'd3, 2'd2, 1'b1, rnd256(), "R8 half high");
    run_op(pa, pb, 2'd0, 2'd3, 1'b0, 2'd2, 2'd3, 1'b1, rnd256(), "R10 reserved mode");
    idle("R11 write pulse ends");

    // mixed random traffic, idle cycles between some ops
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 4) == 0) idle("R9 random idle");
      else run_op(rnd256(), rnd256(), 2'($urandom), 2'($urandom),
                  ($urandom_range(0, 5) == 0), 2'($urandom), 2'($urandom),
                  1'($urandom), rnd256(), "R11 random");
    end
    summary();
  end
endmodule